// File: doc/BRIEF.md
# Multi-Device Microwire Master Controller

This block sits on a simple synchronous host register bus and runs a Microwire-style serial bus to as many as eight peripherals. Each peripheral has its own chip-select pin. The host starts a transfer by writing one data byte to the address of the target device. The block then asserts that device's chip select and clocks out 8 or 16 bits, most significant bit first. It captures the bits that come back on the serial input, releases the chip select and raises a done flag. The status byte(s) returned by the peripheral are then read from the same locations the host wrote.

Each channel has its own word length bit and its own clock polarity bit. For a 16-bit channel the host first loads the low byte into a shared low-byte register, and then writes the high byte to the device address, which starts the transfer. A generic start address uses the settings of channel 7 and asserts no chip select, so software can frame that transfer with the general-purpose pin register. The chip-select pins leave reset as inputs. A pin-direction register turns selected pins into outputs, and the pin register also serves as a general-purpose port. The serial clock is the system clock divided by a parameter.

Top module: `mwire_multi_master`

## Requirements
- R1: A write to address n (0..7) while idle starts a transfer to device n. During the transfer cs_o[n] is 0 and every other chip-select output keeps its register value.
- R2: The chip select is low for CLK_DIV system cycles with the serial clock idle before the first active clock edge. It goes high again on the cycle the last bit completes.
- R3: Mode bit n (register 0xA, bit n) selects 8 clock pulses when 0 and 16 when 1.
- R4: A 16-bit transfer sends {byte written to the device address, low-byte register at 0x9}.
- R5: In the cycle after the start write, so_o carries the word's MSB and so_oe_o is 1. Data goes out MSB first.
- R6: The done flag (done_o, register 0xE bit 0) goes to 0 on the start write and to 1 when the last bit completes. so_oe_o is 0 whenever done is 1.
- R7: The returned status is read at the device address (8-bit: the only byte, 16-bit: the high byte). In 16-bit mode the low returned byte replaces the contents of register 0x9.
- R8: Polarity bit n (register 0xB) set to 0 gives an idle-low clock that samples si_i on the rising edge. Set to 1, it gives an idle-high clock that samples on the falling edge. so_o changes only while the clock is at its idle level.
- R9: A write to address 0x8 starts a transfer with channel 7's mode and polarity and drives no chip select low. Its status is read back at 0x8.
- R10: After reset cs_oe_o is 0, done is 1 and so_oe_o is 0. Register 0xC bit n=1 makes pin n an output driven from register 0xD. Reading 0xD returns the register bit for output pins and cs_i for input pins.
- R11: Writes to addresses 0x0..0x8 during a transfer are ignored: no chip select changes, done stays 0, the transfer in progress completes unchanged, and the status of the ignored device is unchanged.
- R12: Register reads: 0xA mode, 0xB polarity, 0xC pin direction, 0xD pin port, 0xE done in bit 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe, one cycle per write |
| addr_i | input | 4 | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data for addr_i (combinational) |
| sk_o | output | 1 | Serial clock |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Serial data out enable (0 = high impedance) |
| si_i | input | 1 | Serial data in |
| cs_o | output | 8 | Chip-select / general-purpose pin values |
| cs_oe_o | output | 8 | Chip-select pin output enables |
| cs_i | input | 8 | Chip-select pin input levels |
| done_o | output | 1 | Transfer done flag |

## Verification
The checker assumes that the host strobes wr_i for one cycle with a stable address. It also assumes that si_i changes only while the serial clock is at its idle level, and that polarity is not rewritten for the channel in flight. The bench's peripheral model moves si_i only on the inactive clock edge and captures so_o only on the active edge, and every register write is a single-cycle strobe aligned to the falling system clock edge. Writes issued during a transfer are deliberate: they target other devices to show that they are dropped.

// File: rtl/mwm_pkg.sv
package mwm_pkg;
  localparam int NDEV = 8;
  localparam int DEVW = $clog2(NDEV);
  localparam int DW   = 8;
  localparam int WW   = 2 * DW;
  localparam int AW   = 4;
  localparam int CHW  = $clog2(NDEV + 1);

  localparam logic [AW-1:0] A_GEN  = AW'(NDEV);
  localparam logic [AW-1:0] A_LOW  = AW'(NDEV + 1);
  localparam logic [AW-1:0] A_MODE = AW'(NDEV + 2);
  localparam logic [AW-1:0] A_POL  = AW'(NDEV + 3);
  localparam logic [AW-1:0] A_PDIR = AW'(NDEV + 4);
  localparam logic [AW-1:0] A_PORT = AW'(NDEV + 5);
  localparam logic [AW-1:0] A_STAT = AW'(NDEV + 6);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_ACT, S_INA} seq_st_e;

  typedef struct packed {
    logic [CHW-1:0] chan;
    logic           wide;
    logic           pol;
  } xfer_cfg_t;
endpackage

// File: rtl/mwm_regs.sv
module mwm_regs
  import mwm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            busy_i,
  input  logic            done_i,
  input  logic            fin_i,
  input  xfer_cfg_t       fin_cfg_i,
  input  logic [WW-1:0]   rx_i,
  input  logic [NDEV-1:0] cs_pin_i,
  output logic            start_o,
  output xfer_cfg_t       start_cfg_o,
  output logic [WW-1:0]   start_word_o,
  output logic [NDEV-1:0] pdir_o,
  output logic [NDEV-1:0] port_o
);
  logic [NDEV-1:0] mode_q, pol_q, pdir_q, port_q;
  logic [DW-1:0]   low_q;
  logic [DW-1:0]   stat_q [NDEV+1];
  logic [DEVW-1:0] cfg_idx;
  logic            dev_addr;

  assign dev_addr = addr_i <= A_GEN;
  // generic start borrows the top channel's settings
  assign cfg_idx  = (addr_i == A_GEN) ? DEVW'(NDEV - 1) : addr_i[DEVW-1:0];
  assign start_o  = wr_i && dev_addr && !busy_i;

  always_comb begin
    start_cfg_o.chan = CHW'(addr_i);
    start_cfg_o.wide = mode_q[cfg_idx];
    start_cfg_o.pol  = pol_q[cfg_idx];
  end
  assign start_word_o = {wdata_i, low_q};
  assign pdir_o       = pdir_q;
  assign port_o       = port_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      pol_q  <= '0;
      pdir_q <= '0;
      port_q <= '1;
      low_q  <= '0;
      for (int i = 0; i <= NDEV; i++) stat_q[i] <= '0;
    end else begin
      if (wr_i) begin
        case (addr_i)
          A_LOW:  low_q  <= wdata_i;
          A_MODE: mode_q <= wdata_i[NDEV-1:0];
          A_POL:  pol_q  <= wdata_i[NDEV-1:0];
          A_PDIR: pdir_q <= wdata_i[NDEV-1:0];
          A_PORT: port_q <= wdata_i[NDEV-1:0];
          default: ;
        endcase
      end
      // returned status wins over a concurrent host write
      if (fin_i) begin
        stat_q[fin_cfg_i.chan] <= fin_cfg_i.wide ? rx_i[WW-1:DW] : rx_i[DW-1:0];
        if (fin_cfg_i.wide) low_q <= rx_i[DW-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (dev_addr) begin
      rdata_o = stat_q[CHW'(addr_i)];
    end else begin
      case (addr_i)
        A_LOW:  rdata_o = low_q;
        A_MODE: rdata_o = DW'(mode_q);
        A_POL:  rdata_o = DW'(pol_q);
        A_PDIR: rdata_o = DW'(pdir_q);
        A_PORT: rdata_o = DW'((pdir_q & port_q) | (~pdir_q & cs_pin_i));
        A_STAT: rdata_o = DW'(done_i);
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mwm_seq.sv
module mwm_seq
  import mwm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  xfer_cfg_t     cfg_i,
  input  logic [WW-1:0] word_i,
  input  logic          si_i,
  output logic          sk_o,
  output logic          so_o,
  output logic          so_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fin_o,
  output xfer_cfg_t     cfg_o,
  output logic [WW-1:0] rx_o
);
  localparam int TW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [TW-1:0] T_LOAD = TW'(CLK_DIV - 1);
  localparam int BW = $clog2(WW + 1);

  seq_st_e       st_q;
  logic [TW-1:0] tmr_q;
  logic [BW-1:0] bits_q, nbits;
  logic [WW-1:0] sh_q, rx_q;
  xfer_cfg_t     cfg_q;
  logic          done_q, fin_q, tmr_end;

  assign tmr_end = tmr_q == '0;
  assign nbits   = cfg_q.wide ? BW'(WW) : BW'(DW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      tmr_q  <= '0;
      bits_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      cfg_q  <= '0;
      done_q <= 1'b1;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q   <= S_LEAD;
          tmr_q  <= T_LOAD;
          sh_q   <= word_i;
          cfg_q  <= cfg_i;
          bits_q <= '0;
          rx_q   <= '0;
          done_q <= 1'b0;
        end
        S_LEAD, S_INA: if (tmr_end) begin
          // active edge: capture returning bit
          st_q   <= S_ACT;
          tmr_q  <= T_LOAD;
          rx_q   <= {rx_q[WW-2:0], si_i};
          bits_q <= bits_q + 1'b1;
        end else begin
          tmr_q <= tmr_q - 1'b1;
        end
        S_ACT: if (tmr_end) begin
          tmr_q <= T_LOAD;
          if (bits_q == nbits) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
            fin_q  <= 1'b1;
          end else begin
            st_q <= S_INA;
            sh_q <= {sh_q[WW-2:0], 1'b0};
          end
        end else begin
          tmr_q <= tmr_q - 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = st_q != S_IDLE;
  assign so_oe_o = busy_o;
  assign so_o    = sh_q[WW-1];
  assign sk_o    = cfg_q.pol ^ (st_q == S_ACT);
  assign done_o  = done_q;
  assign fin_o   = fin_q;
  assign cfg_o   = cfg_q;
  assign rx_o    = rx_q;
endmodule

// File: rtl/mwm_cs.sv
module mwm_cs
  import mwm_pkg::*;
(
  input  logic            busy_i,
  input  logic [CHW-1:0]  chan_i,
  input  logic [NDEV-1:0] pdir_i,
  input  logic [NDEV-1:0] port_i,
  output logic [NDEV-1:0] cs_o,
  output logic [NDEV-1:0] cs_oe_o
);
  for (genvar g = 0; g < NDEV; g++) begin : g_pin
    assign cs_o[g]    = (busy_i && chan_i == CHW'(g)) ? 1'b0 : port_i[g];
    assign cs_oe_o[g] = pdir_i[g];
  end
endmodule

// File: rtl/mwire_multi_master.sv
module mwire_multi_master
  import mwm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            sk_o,
  output logic            so_o,
  output logic            so_oe_o,
  input  logic            si_i,
  output logic [NDEV-1:0] cs_o,
  output logic [NDEV-1:0] cs_oe_o,
  input  logic [NDEV-1:0] cs_i,
  output logic            done_o
);
  logic            start, busy, done, fin;
  xfer_cfg_t       start_cfg, cur_cfg;
  logic [WW-1:0]   start_word, rx;
  logic [NDEV-1:0] pdir, port;
  logic [CHW-1:0]  xfer_chan;
  logic            xfer_pol;

  assign xfer_chan = cur_cfg.chan;
  assign xfer_pol  = cur_cfg.pol;
  assign done_o    = done;

  mwm_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .done_i(done), .fin_i(fin), .fin_cfg_i(cur_cfg), .rx_i(rx),
    .cs_pin_i(cs_i), .start_o(start), .start_cfg_o(start_cfg),
    .start_word_o(start_word), .pdir_o(pdir), .port_o(port)
  );

  mwm_seq #(.CLK_DIV(CLK_DIV)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .cfg_i(start_cfg), .word_i(start_word),
    .si_i, .sk_o, .so_o, .so_oe_o, .busy_o(busy), .done_o(done),
    .fin_o(fin), .cfg_o(cur_cfg), .rx_o(rx)
  );

  mwm_cs u_cs (
    .busy_i(busy), .chan_i(xfer_chan), .pdir_i(pdir), .port_i(port),
    .cs_o, .cs_oe_o
  );
endmodule

// File: rtl/mwm_chk.sv
module mwm_chk
  import mwm_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_i,
  input logic [AW-1:0]   addr_i,
  input logic            done_o,
  input logic            so_oe_o,
  input logic            so_o,
  input logic            sk_o,
  input logic [NDEV-1:0] cs_o,
  input logic            busy_i,
  input logic [CHW-1:0]  chan_i,
  input logic            pol_i
);
  p_cs_active_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && chan_i < CHW'(NDEV)) |-> !cs_o[chan_i[DEVW-1:0]]);

  p_start_by_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(so_oe_o) |-> $past(wr_i));

  p_done_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> ($past(wr_i) && $past(addr_i) <= A_GEN));

  p_tristate_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !so_oe_o);

  p_so_idle_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (so_oe_o && $past(so_oe_o) && !$stable(so_o)) |-> (sk_o == pol_i));

  p_sk_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!so_oe_o && $past(!so_oe_o)) |-> $stable(sk_o));

  p_busy_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_i && addr_i <= A_GEN) |=> $stable(chan_i));
endmodule

bind mwire_multi_master mwm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
  .done_o(done_o), .so_oe_o(so_oe_o), .so_o(so_o), .sk_o(sk_o), .cs_o(cs_o),
  .busy_i(busy), .chan_i(xfer_chan), .pol_i(xfer_pol)
);

// File: tb/mwire_multi_master_bench.sv
module mwire_multi_master_bench;
  localparam int D = 4;

  logic       clk = 0, rst_n = 0, wr = 0, si = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, cs_in = 8'h3C;
  logic [7:0] rdata, cs, cs_oe;
  logic       sk, so, so_oe, done;

  int total = 0, bad = 0;

  mwire_multi_master #(.CLK_DIV(D)) u_mwire_multi_master (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sk_o(sk), .so_o(so), .so_oe_o(so_oe), .si_i(si),
    .cs_o(cs), .cs_oe_o(cs_oe), .cs_i(cs_in), .done_o(done)
  );

  always #10 clk = ~clk;

  // peripheral model: shift on inactive edge, capture on active edge
  logic        tb_pol = 0, oe_prev = 0, sk_prev = 0;
  logic [15:0] tb_reply = 0, sh = 0, rx_cap = 0;
  int          pulses = 0;

  always @(so_oe or sk) begin
    if (so_oe === 1'b1 && oe_prev !== 1'b1) begin
      sh = tb_reply; si = sh[15]; rx_cap = 0; pulses = 0;
    end else if (so_oe === 1'b1 && sk !== sk_prev) begin
      if (sk != tb_pol) begin
        rx_cap = {rx_cap[14:0], so}; pulses++;
      end else if (pulses > 0) begin
        sh = sh << 1; si = sh[15];
      end
    end
    oe_prev = so_oe; sk_prev = sk;
  end

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk("R6 completion", done, 1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R10 reset cs_oe", cs_oe, 0);
    chk("R10 reset done", done, 1);
    chk("R10 reset so_oe", so_oe, 0);
    host_rd(4'hE, d); chk("R12 status read", d, 1);
    host_rd(4'hD, d); chk("R10 port reads inputs", d, 8'h3C);
  endtask

  task automatic t_8bit();
    logic [7:0] d;
    host_wr(4'hC, 8'hFF); host_wr(4'hD, 8'hFF);
    chk("R10 outputs enabled", cs_oe, 8'hFF);
    tb_pol = 0; tb_reply = 16'h3C00;
    host_wr(4'h3, 8'hA5);
    chk("R1 cs3 low", cs, 8'hF7);
    chk("R5 msb out", so, 1);
    chk("R5 so enabled", so_oe, 1);
    chk("R6 done cleared", done, 0);
    chk("R8 idle low", sk, 0);
    wait_done();
    chk("R3 8 pulses", pulses, 8);
    chk("R5 msb first", rx_cap[7:0], 8'hA5);
    chk("R2 cs released", cs, 8'hFF);
    chk("R6 tristate", so_oe, 0);
    host_rd(4'h3, d); chk("R7 8-bit status", d, 8'h3C);
  endtask

  task automatic t_16bit();
    logic [7:0] d;
    int lead = 0;
    host_wr(4'hA, 8'h20); host_wr(4'hB, 8'h20);
    host_wr(4'h9, 8'h34);
    tb_pol = 1; tb_reply = 16'hBEEF;
    host_wr(4'h5, 8'h12);
    chk("R8 idle high", sk, 1);
    chk("R1 cs5 low", cs, 8'hDF);
    chk("R5 msb out", so, 0);
    while (sk == 1'b1 && lead < 100) begin @(negedge clk); lead++; end
    chk("R2 lead time", lead, D);
    wait_done();
    chk("R3 16 pulses", pulses, 16);
    chk("R4 word", rx_cap, 16'h1234);
    host_rd(4'h5, d); chk("R7 high status", d, 8'hBE);
    host_rd(4'h9, d); chk("R7 low status", d, 8'hEF);
    host_rd(4'hA, d); chk("R12 mode read", d, 8'h20);
  endtask

  task automatic t_busy();
    logic [7:0] d;
    tb_pol = 0; tb_reply = 16'h8100;
    host_wr(4'h0, 8'h6E);
    repeat (10) @(negedge clk);
    host_wr(4'h1, 8'h77);
    chk("R11 cs1 untouched", cs[1], 1);
    chk("R11 cs0 held", cs[0], 0);
    chk("R11 done stays 0", done, 0);
    host_rd(4'hE, d); chk("R12 status busy", d, 0);
    wait_done();
    chk("R11 pulses", pulses, 8);
    chk("R11 data intact", rx_cap[7:0], 8'h6E);
    host_rd(4'h0, d); chk("R7 dev0 status", d, 8'h81);
    host_rd(4'h1, d); chk("R11 dev1 status", d, 0);
    repeat (5) @(negedge clk);
    chk("R11 no late start", so_oe, 0);
  endtask

  task automatic t_generic();
    logic [7:0] d;
    host_wr(4'hA, 8'hA0); host_wr(4'hB, 8'hA0);
    host_wr(4'h9, 8'h5A);
    tb_pol = 1; tb_reply = 16'h9966;
    host_wr(4'h8, 8'hC3);
    chk("R9 no cs", cs, 8'hFF);
    chk("R9 ch7 pol", sk, 1);
    repeat (20) @(negedge clk);
    chk("R9 no cs mid", cs, 8'hFF);
    wait_done();
    chk("R9 ch7 mode", pulses, 16);
    chk("R9 word", rx_cap, 16'hC35A);
    host_rd(4'h8, d); chk("R9 status high", d, 8'h99);
    host_rd(4'h9, d); chk("R7 status low", d, 8'h66);
  endtask

  task automatic t_port();
    logic [7:0] d;
    host_wr(4'hC, 8'h0F); host_wr(4'hD, 8'hA5);
    chk("R10 pin dir", cs_oe, 8'h0F);
    chk("R10 pin drive", cs[3:0], 4'h5);
    host_rd(4'hD, d); chk("R10 port read", d, 8'h35);
    host_rd(4'hC, d); chk("R12 dir read", d, 8'h0F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    total++; bad++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_8bit();
    t_16bit();
    t_busy();
    t_generic();
    t_port();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule